// File: doc/BRIEF.md
# Blocking Cache Miss and Writeback Holding Controller

This block sits beside the tag and data arrays of a blocking cache. It holds at most one outstanding miss in a miss slot and at most one outgoing write in a write slot. Each slot has its own "blocked" flag, which tells the cache to stall, and its own bus-request flag. A single issue port offers the next entry to the memory bus with a valid/ready handshake and a 1-bit slot select. Responses come back tagged with the same select, so no address compare is needed. A cacheable miss goes out as a line-fill command, and its original command is handed back to the cache when the fill completes. A non-fill response passes its data to the one waiting requester. A pending miss can be cancelled for a given thread. Evictions written back are counted per thread.

Each slot runs a three-state machine. EMPTY moves to PENDING on ALLOC. PENDING moves to BUSY on ISSUE of a request that expects a reply. PENDING returns to EMPTY on ISSUE of a no-reply request, or on a SQUASH of the miss slot. BUSY returns to EMPTY on RETIRE, when the matching response arrives. A slot's blocked flag is its state being other than EMPTY. Its bus-request flag is its state being PENDING.

Command encoding on `req_cmd` and `bus_cmd`: 0 = read, 1 = write, 2 = writeback (always no-reply), 3 = line fill (bus only). Slot select on `bus_sel` and `rsp_sel`: 0 = miss slot, 1 = write slot.

Top module: `blk_miss_buf`

## Requirements
- R1: The address stored and put on `bus_addr` is the request address with its low log2(BLK_BYTES) bits (4 for the default 16) forced to zero.
- R2: A write or writeback goes to the write slot when it is uncacheable, when `cfg_wr_alloc` is 0, or when it expects no reply. Any other request goes to the miss slot.
- R3: Accepting into the miss slot raises `blk_no_mshr` and `breq_mshr`. Accepting into the write slot raises `blk_no_wbuf` and `breq_wb`. The other slot's flags are untouched.
- R4: While the target slot is occupied, `req_ready` is 0, the request is rejected, and the held entry is not changed.
- R5: A cacheable miss is issued with `bus_cmd`=3 and `bus_fill`=1. An uncacheable miss is issued with its own command and `bus_fill`=0.
- R6: When both slots are pending, the miss slot (`bus_sel`=0) is offered first. The write slot is offered only when no miss is pending.
- R7: On a bus handshake, the issued slot's bus-request flag drops. A no-reply entry also frees its slot and clears its blocked flag at once. Any other entry stays blocked.
- R8: A response to a line fill pulses `fill_done`, presents the saved original command on `fill_cmd`, and frees the miss slot.
- R9: A non-fill response delivers `tgt_valid` with the waiting requester's thread and the response data for a read (0 for a write), then frees the selected slot.
- R10: `squash_valid` whose thread equals the miss slot's thread drops its target. If the miss is still pending, the slot is freed and both miss flags clear. If it is already issued, the slot stays until the response, which then delivers no target. A squash for another thread has no effect.
- R11: Each accepted writeback adds one to the counter of `req_thread`, or to thread 0's counter when `req_has_ctx` is 0. Counter g is `wb_cnt[g*CW +: CW]`.
- R12: After reset, both slots are empty, every flag and `bus_valid` is 0, all counters are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_alloc | input | 1 | Write-allocate enable |
| req_valid | input | 1 | Miss or writeback request valid |
| req_ready | output | 1 | Target slot is free |
| req_cmd | input | 2 | Request command (0 read, 1 write, 2 writeback) |
| req_uncache | input | 1 | Request is uncacheable |
| req_noresp | input | 1 | Request expects no reply |
| req_has_ctx | input | 1 | `req_thread` is meaningful |
| req_thread | input | TW | Requesting thread |
| req_addr | input | AW | Request address |
| req_data | input | DW | Write data |
| blk_no_mshr | output | 1 | Miss slot occupied |
| blk_no_wbuf | output | 1 | Write slot occupied |
| breq_mshr | output | 1 | Miss slot waiting for the bus |
| breq_wb | output | 1 | Write slot waiting for the bus |
| bus_valid | output | 1 | An entry is offered to the bus |
| bus_ready | input | 1 | Bus takes the offered entry |
| bus_sel | output | 1 | Offered slot (0 miss, 1 write) |
| bus_addr | output | AW | Offered block address |
| bus_cmd | output | 2 | Bus command (3 = line fill) |
| bus_fill | output | 1 | Offered entry is a line fill |
| bus_data | output | DW | Offered write data |
| rsp_valid | input | 1 | Bus response valid |
| rsp_sel | input | 1 | Slot the response belongs to |
| rsp_data | input | DW | Response data |
| fill_done | output | 1 | Line fill completed |
| fill_cmd | output | 2 | Original command of the completed fill |
| tgt_valid | output | 1 | Data delivered to the waiting requester |
| tgt_thread | output | TW | Thread of that requester |
| tgt_data | output | DW | Read data for that requester |
| squash_valid | input | 1 | Squash request |
| squash_thread | input | TW | Thread to squash |
| wb_cnt | output | NT*CW | Per-thread writeback counters |

## Verification
Requests are driven through each routing case: a cacheable read, an uncacheable read, an uncacheable write, a write with and without write-allocate, and writebacks with and without a thread context. These separate the miss slot from the write slot, and fills from pass-through commands. A scoreboard queues the expected bus issue order when both slots are pending, which tells miss priority apart from arrival order. Requests to occupied slots are followed by the issue of the held entry, to show it was not overwritten. Squashes are applied with a wrong thread, on a pending miss and on an issued miss, so that no effect, an immediate free and a deferred free with a suppressed target can each be seen.

// File: rtl/mb_pkg.sv
package mb_pkg;
    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_WBACK = 2'd2,
        CMD_FILL  = 2'd3
    } cmd_t;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PEND  = 2'd1,
        ST_BUSY  = 2'd2
    } ent_st_t;

    localparam logic SEL_MISS = 1'b0;
    localparam logic SEL_WBUF = 1'b1;
endpackage

// File: rtl/mb_entry.sv
module mb_entry
    import mb_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int TW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_i,
    input  logic [AW-1:0] a_addr,
    input  cmd_t          a_cmd,
    input  logic [TW-1:0] a_thread,
    input  logic [DW-1:0] a_data,
    input  logic          a_noresp,
    input  logic          a_fill,
    input  logic          issue_i,
    input  logic          retire_i,
    input  logic          squash_i,
    output ent_st_t       st_o,
    output logic [AW-1:0] addr_o,
    output cmd_t          cmd_o,
    output logic [TW-1:0] thread_o,
    output logic [DW-1:0] data_o,
    output logic          fill_o,
    output logic          tgt_o
);
    ent_st_t       st_q, st_d;
    logic [AW-1:0] addr_q;
    cmd_t          cmd_q;
    logic [TW-1:0] thread_q;
    logic [DW-1:0] data_q;
    logic          noresp_q, fill_q, tgt_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    // Transitions: ALLOC, ISSUE, SQUASH, RETIRE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: if (alloc_i) st_d = ST_PEND;
            ST_PEND: begin
                if (squash_i)     st_d = ST_EMPTY;
                else if (issue_i) st_d = noresp_q ? ST_EMPTY : ST_BUSY;
            end
            ST_BUSY:  if (retire_i) st_d = ST_EMPTY;
            default:  st_d = ST_EMPTY;
        endcase
    end

    // Payload held while the slot is occupied
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            cmd_q    <= CMD_READ;
            thread_q <= '0;
            data_q   <= '0;
            noresp_q <= 1'b0;
            fill_q   <= 1'b0;
            tgt_q    <= 1'b0;
        end else if (alloc_i && st_q == ST_EMPTY) begin
            addr_q   <= a_addr;
            cmd_q    <= a_cmd;
            thread_q <= a_thread;
            data_q   <= a_data;
            noresp_q <= a_noresp;
            fill_q   <= a_fill;
            tgt_q    <= !a_noresp;
        end else if (squash_i) begin
            tgt_q    <= 1'b0;
        end
    end

    assign st_o     = st_q;
    assign addr_o   = addr_q;
    assign cmd_o    = cmd_q;
    assign thread_o = thread_q;
    assign data_o   = data_q;
    assign fill_o   = fill_q;
    assign tgt_o    = tgt_q;
endmodule

// File: rtl/mb_issue_arb.sv
module mb_issue_arb
    import mb_pkg::*;
(
    input  logic m_pend,
    input  logic w_pend,
    input  logic m_hold,
    input  logic bus_ready,
    output logic bus_valid,
    output logic bus_sel,
    output logic m_issue,
    output logic w_issue
);
    logic m_go;

    always_comb begin
        m_go      = m_pend && !m_hold;
        bus_valid = m_go || w_pend;
        bus_sel   = m_go ? SEL_MISS : SEL_WBUF;
        m_issue   = bus_ready && m_go;
        w_issue   = bus_ready && !m_go && w_pend;
    end
endmodule

// File: rtl/mb_wb_ctr.sv
module mb_wb_ctr #(
    parameter int NT = 4,
    parameter int CW = 8,
    parameter int TW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           inc_i,
    input  logic [TW-1:0]  idx_i,
    output logic [NT*CW-1:0] cnt_o
);
    for (genvar g = 0; g < NT; g++) begin : g_ctr
        logic [CW-1:0] c_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                          c_q <= '0;
            else if (inc_i && idx_i == TW'(g))   c_q <= c_q + 1'b1;
        end
        assign cnt_o[g*CW +: CW] = c_q;
    end
endmodule

// File: rtl/blk_miss_buf.sv
module blk_miss_buf
    import mb_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int BLK_BYTES = 16,
    parameter int NT        = 4,
    parameter int CW        = 8,
    localparam int TW       = $clog2(NT)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr_alloc,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [1:0]     req_cmd,
    input  logic           req_uncache,
    input  logic           req_noresp,
    input  logic           req_has_ctx,
    input  logic [TW-1:0]  req_thread,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_data,
    output logic           blk_no_mshr,
    output logic           blk_no_wbuf,
    output logic           breq_mshr,
    output logic           breq_wb,
    output logic           bus_valid,
    input  logic           bus_ready,
    output logic           bus_sel,
    output logic [AW-1:0]  bus_addr,
    output logic [1:0]     bus_cmd,
    output logic           bus_fill,
    output logic [DW-1:0]  bus_data,
    input  logic           rsp_valid,
    input  logic           rsp_sel,
    input  logic [DW-1:0]  rsp_data,
    output logic           fill_done,
    output logic [1:0]     fill_cmd,
    output logic           tgt_valid,
    output logic [TW-1:0]  tgt_thread,
    output logic [DW-1:0]  tgt_data,
    input  logic           squash_valid,
    input  logic [TW-1:0]  squash_thread,
    output logic [NT*CW-1:0] wb_cnt
);
    localparam logic [AW-1:0] OFF_MASK = AW'(BLK_BYTES - 1);

    cmd_t          r_cmd;
    logic          is_wr, noresp, to_wb, accept, m_alloc, w_alloc;
    logic [AW-1:0] blk_addr;
    logic          sq_hit, m_issue, w_issue, m_retire, w_retire;

    ent_st_t       m_st, w_st;
    logic [AW-1:0] m_addr, w_addr;
    cmd_t          m_cmd, w_cmd;
    logic [TW-1:0] m_thread, w_thread;
    logic [DW-1:0] m_data, w_data;
    logic          m_fill, w_fill, m_tgt, w_tgt;

    // Request routing and acceptance
    always_comb begin
        r_cmd     = cmd_t'(req_cmd);
        is_wr     = (r_cmd == CMD_WRITE) || (r_cmd == CMD_WBACK);
        noresp    = req_noresp || (r_cmd == CMD_WBACK);
        to_wb     = is_wr && (req_uncache || !cfg_wr_alloc || noresp);
        req_ready = to_wb ? (w_st == ST_EMPTY) : (m_st == ST_EMPTY);
        accept    = req_valid && req_ready;
        m_alloc   = accept && !to_wb;
        w_alloc   = accept && to_wb;
        blk_addr  = req_addr & ~OFF_MASK;
        sq_hit    = squash_valid && (m_st != ST_EMPTY) && (m_thread == squash_thread);
        m_retire  = rsp_valid && (rsp_sel == SEL_MISS) && (m_st == ST_BUSY);
        w_retire  = rsp_valid && (rsp_sel == SEL_WBUF) && (w_st == ST_BUSY);
    end

    mb_entry #(.AW(AW), .DW(DW), .TW(TW)) u_miss (
        .clk(clk), .rst_n(rst_n), .alloc_i(m_alloc), .a_addr(blk_addr), .a_cmd(r_cmd),
        .a_thread(req_thread), .a_data(req_data), .a_noresp(noresp), .a_fill(!req_uncache),
        .issue_i(m_issue), .retire_i(m_retire), .squash_i(sq_hit),
        .st_o(m_st), .addr_o(m_addr), .cmd_o(m_cmd), .thread_o(m_thread), .data_o(m_data),
        .fill_o(m_fill), .tgt_o(m_tgt)
    );

    mb_entry #(.AW(AW), .DW(DW), .TW(TW)) u_wbuf (
        .clk(clk), .rst_n(rst_n), .alloc_i(w_alloc), .a_addr(blk_addr), .a_cmd(r_cmd),
        .a_thread(req_thread), .a_data(req_data), .a_noresp(noresp), .a_fill(1'b0),
        .issue_i(w_issue), .retire_i(w_retire), .squash_i(1'b0),
        .st_o(w_st), .addr_o(w_addr), .cmd_o(w_cmd), .thread_o(w_thread), .data_o(w_data),
        .fill_o(w_fill), .tgt_o(w_tgt)
    );

    mb_issue_arb u_arb (
        .m_pend(m_st == ST_PEND), .w_pend(w_st == ST_PEND), .m_hold(sq_hit),
        .bus_ready(bus_ready), .bus_valid(bus_valid), .bus_sel(bus_sel),
        .m_issue(m_issue), .w_issue(w_issue)
    );

    mb_wb_ctr #(.NT(NT), .CW(CW), .TW(TW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .inc_i(accept && r_cmd == CMD_WBACK),
        .idx_i(req_has_ctx ? req_thread : '0), .cnt_o(wb_cnt)
    );

    // Output process: flags, issue payload, response routing
    always_comb begin
        logic    r_busy, r_fill, r_tgt;
        cmd_t    r_ocmd;
        blk_no_mshr = (m_st != ST_EMPTY);
        blk_no_wbuf = (w_st != ST_EMPTY);
        breq_mshr   = (m_st == ST_PEND);
        breq_wb     = (w_st == ST_PEND);

        bus_addr = (bus_sel == SEL_MISS) ? m_addr : w_addr;
        bus_data = (bus_sel == SEL_MISS) ? m_data : w_data;
        bus_fill = (bus_sel == SEL_MISS) ? m_fill : w_fill;
        bus_cmd  = bus_fill ? CMD_FILL : ((bus_sel == SEL_MISS) ? m_cmd : w_cmd);

        r_busy = (rsp_sel == SEL_MISS) ? (m_st == ST_BUSY) : (w_st == ST_BUSY);
        r_fill = (rsp_sel == SEL_MISS) ? m_fill : w_fill;
        r_tgt  = (rsp_sel == SEL_MISS) ? m_tgt : w_tgt;
        r_ocmd = (rsp_sel == SEL_MISS) ? m_cmd : w_cmd;

        fill_done  = rsp_valid && r_busy && r_fill;
        fill_cmd   = m_cmd;
        tgt_valid  = rsp_valid && r_busy && !r_fill && r_tgt;
        tgt_thread = (rsp_sel == SEL_MISS) ? m_thread : w_thread;
        tgt_data   = (r_ocmd == CMD_READ) ? rsp_data : '0;
    end
endmodule

// File: rtl/mb_chk.sv
module mb_chk #(
    parameter int NT = 4,
    parameter int CW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_cmd,
    input logic             blk_no_mshr,
    input logic             blk_no_wbuf,
    input logic             breq_mshr,
    input logic             breq_wb,
    input logic             bus_valid,
    input logic             bus_ready,
    input logic             bus_sel,
    input logic [1:0]       bus_cmd,
    input logic             bus_fill,
    input logic             rsp_valid,
    input logic             rsp_sel,
    input logic             squash_valid,
    input logic             fill_done,
    input logic [NT*CW-1:0] wb_cnt
);
    assert_breq_blk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (breq_mshr |-> blk_no_mshr) and (breq_wb |-> blk_no_wbuf));

    assert_no_overwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_no_mshr && !(bus_valid && bus_ready && !bus_sel) && !(rsp_valid && !rsp_sel)
         && !squash_valid) |=> blk_no_mshr);

    assert_fill_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_fill) |-> (bus_cmd == 2'd3));

    assert_miss_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && breq_mshr && !squash_valid) |-> !bus_sel);

    assert_issue_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && !bus_sel) |=> !breq_mshr);

    assert_fill_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> !blk_no_mshr);

    assert_cnt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready && req_cmd == 2'd2) |=> $stable(wb_cnt));
endmodule

bind blk_miss_buf mb_chk #(.NT(NT), .CW(CW)) chk_i (.*);

// File: tb/blk_miss_buf_tb_top.sv
`timescale 1ns/100ps
module blk_miss_buf_tb_top;
    localparam int AW = 32, DW = 32, NT = 4, CW = 8, TW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_wr_alloc = 1'b1;
    logic req_valid = 0, req_uncache = 0, req_noresp = 0, req_has_ctx = 0;
    logic [1:0] req_cmd = 0;
    logic [TW-1:0] req_thread = 0, squash_thread = 0;
    logic [AW-1:0] req_addr = 0;
    logic [DW-1:0] req_data = 0, rsp_data = 0;
    logic bus_ready = 0, rsp_valid = 0, rsp_sel = 0, squash_valid = 0;
    logic req_ready, blk_no_mshr, blk_no_wbuf, breq_mshr, breq_wb;
    logic bus_valid, bus_sel, bus_fill, fill_done, tgt_valid;
    logic [AW-1:0] bus_addr;
    logic [1:0] bus_cmd, fill_cmd;
    logic [DW-1:0] bus_data, tgt_data;
    logic [TW-1:0] tgt_thread;
    logic [NT*CW-1:0] wb_cnt;

    int n_chk = 0, n_fail = 0;
    logic          q_sel[$];
    logic [AW-1:0] q_addr[$];
    logic [1:0]    q_cmd[$];
    logic          q_fill[$];

    always #2 clk = ~clk;

    blk_miss_buf dut_i (.*);

    task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] cnt(int t);
        return wb_cnt[t*CW +: CW];
    endfunction

    task automatic send(logic [1:0] c, logic unc, logic nr, logic ctx, logic [TW-1:0] th,
                        logic [AW-1:0] a, logic [DW-1:0] d, output logic acc);
        @(negedge clk);
        req_cmd = c; req_uncache = unc; req_noresp = nr; req_has_ctx = ctx;
        req_thread = th; req_addr = a; req_data = d; req_valid = 1'b1;
        #1 acc = req_ready;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_issue(logic s, logic [AW-1:0] a, logic [1:0] c, logic f);
        q_sel.push_back(s); q_addr.push_back(a); q_cmd.push_back(c); q_fill.push_back(f);
    endtask

    task automatic issue();
        @(negedge clk); bus_ready = 1'b1;
        @(negedge clk); bus_ready = 1'b0;
    endtask

    task automatic respond(logic s, logic [DW-1:0] d, output logic fd, output logic [1:0] fc,
                           output logic tv, output logic [TW-1:0] tt, output logic [DW-1:0] td);
        @(negedge clk); rsp_valid = 1'b1; rsp_sel = s; rsp_data = d;
        #1 fd = fill_done; fc = fill_cmd; tv = tgt_valid; tt = tgt_thread; td = tgt_data;
        @(negedge clk); rsp_valid = 1'b0;
    endtask

    task automatic squash(logic [TW-1:0] th);
        @(negedge clk); squash_valid = 1'b1; squash_thread = th;
        @(negedge clk); squash_valid = 1'b0;
    endtask

    // Monitor: compare each bus handshake against the scoreboard queue
    initial forever begin
        @(negedge clk); #1;
        if (bus_valid && bus_ready) begin
            if (q_sel.size() == 0) chk("R6 unexpected issue", 64'(bus_sel), 64'hFF);
            else begin
                chk("R6 issue slot", 64'(bus_sel), 64'(q_sel.pop_front()));
                chk("R1 issue address", 64'(bus_addr), 64'(q_addr.pop_front()));
                chk("R5 issue command", 64'(bus_cmd), 64'(q_cmd.pop_front()));
                chk("R5 fill tag", 64'(bus_fill), 64'(q_fill.pop_front()));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog all requirements actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic a, fd, tv;
        logic [1:0] fc;
        logic [TW-1:0] tt;
        logic [DW-1:0] td;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R12 reset state
        chk("R12 flags", {blk_no_mshr, blk_no_wbuf, breq_mshr, breq_wb, bus_valid}, 0);
        chk("R12 counters", 64'(wb_cnt), 0);
        chk("R12 ready", 64'(req_ready), 1);

        // Cacheable read miss, rejected second request, fill
        send(2'd0, 0, 0, 1, 2'd1, 32'h1234, 0, a);
        chk("R3 miss accept", a, 1);
        #1 chk("R3 miss flags", {blk_no_mshr, breq_mshr, blk_no_wbuf, breq_wb}, 4'b1100);
        send(2'd0, 0, 0, 1, 2'd2, 32'h5678, 0, a);
        chk("R4 occupied reject", a, 0);
        expect_issue(0, 32'h1230, 2'd3, 1);
        issue();
        #1 chk("R7 issued stays blocked", {blk_no_mshr, breq_mshr}, 2'b10);
        respond(0, 32'hDEAD, fd, fc, tv, tt, td);
        chk("R8 fill done", {fd, tv}, 2'b10);
        chk("R8 original command", fc, 2'd0);
        #1 chk("R8 miss freed", blk_no_mshr, 0);

        // Uncacheable write and uncacheable read both pending
        send(2'd1, 1, 0, 1, 2'd2, 32'h2004, 32'h11, a);
        #1 chk("R2 uncacheable write to write slot", {blk_no_wbuf, blk_no_mshr}, 2'b10);
        send(2'd0, 1, 0, 1, 2'd3, 32'h3008, 0, a);
        #1 chk("R3 both slots", {breq_mshr, breq_wb}, 2'b11);
        expect_issue(0, 32'h3000, 2'd0, 0);
        expect_issue(1, 32'h2000, 2'd1, 0);
        issue();
        issue();
        respond(1, 32'h77, fd, fc, tv, tt, td);
        chk("R9 write target", {fd, tv}, 2'b01);
        chk("R9 write thread", tt, 2'd2);
        chk("R9 write data zero", td, 0);
        respond(0, 32'hCAFE, fd, fc, tv, tt, td);
        chk("R9 read target", {fd, tv}, 2'b01);
        chk("R9 read thread", tt, 2'd3);
        chk("R9 read data", td, 32'hCAFE);
        #1 chk("R9 both freed", {blk_no_mshr, blk_no_wbuf}, 0);

        // Write-allocate off and on
        cfg_wr_alloc = 1'b0;
        send(2'd1, 0, 0, 1, 2'd0, 32'h4440, 32'h5, a);
        #1 chk("R2 no-allocate write", {blk_no_wbuf, blk_no_mshr}, 2'b10);
        expect_issue(1, 32'h4440, 2'd1, 0);
        issue();
        respond(1, 0, fd, fc, tv, tt, td);
        cfg_wr_alloc = 1'b1;
        send(2'd1, 0, 0, 1, 2'd1, 32'h444C, 32'h6, a);
        #1 chk("R2 allocate write to miss slot", {blk_no_wbuf, blk_no_mshr}, 2'b01);
        expect_issue(0, 32'h4440, 2'd3, 1);
        issue();
        respond(0, 0, fd, fc, tv, tt, td);
        chk("R8 restored write command", {fd, fc}, 3'b101);

        // Writebacks and per-thread counters
        send(2'd2, 0, 0, 1, 2'd2, 32'h5000, 32'h9, a);
        #1 chk("R11 thread 2 count", cnt(2), 1);
        chk("R2 writeback to write slot", {blk_no_wbuf, blk_no_mshr}, 2'b10);
        expect_issue(1, 32'h5000, 2'd2, 0);
        issue();
        #1 chk("R7 no-reply freed at issue", {blk_no_wbuf, breq_wb}, 0);
        send(2'd2, 0, 0, 0, 2'd3, 32'h5100, 32'h1, a);
        #1 chk("R11 no context counts thread 0", {cnt(0), cnt(3)}, 16'h0100);
        send(2'd2, 0, 0, 0, 2'd1, 32'h5200, 32'h2, a);
        #1 chk("R4 occupied writeback rejected", {a, cnt(0)}, 9'h001);
        expect_issue(1, 32'h5100, 2'd2, 0);
        issue();

        // Squash
        send(2'd0, 0, 0, 1, 2'd1, 32'h6000, 0, a);
        squash(2'd0);
        #1 chk("R10 wrong thread no effect", {blk_no_mshr, breq_mshr}, 2'b11);
        squash(2'd1);
        #1 chk("R10 pending squash frees", {blk_no_mshr, breq_mshr, bus_valid}, 0);
        send(2'd0, 1, 0, 1, 2'd2, 32'h7000, 0, a);
        expect_issue(0, 32'h7000, 2'd0, 0);
        issue();
        squash(2'd2);
        #1 chk("R10 issued squash stays", blk_no_mshr, 1);
        respond(0, 32'hBEEF, fd, fc, tv, tt, td);
        chk("R10 no target after squash", tv, 0);
        #1 chk("R10 freed on response", blk_no_mshr, 0);

        // No-reply read
        send(2'd0, 0, 1, 1, 2'd0, 32'h8014, 0, a);
        expect_issue(0, 32'h8010, 2'd3, 1);
        issue();
        #1 chk("R7 no-reply miss freed", blk_no_mshr, 0);

        repeat (3) @(negedge clk);
        chk("R6 scoreboard drained", 64'(q_sel.size()), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule